// File: doc/BRIEF.md
# I/O Voltage Negotiation Controller

This block picks the I/O supply voltage for two port groups on a carrier board. Group 0 serves ports 0 and 1. Group 1 serves port 2. For each port the block receives:
- a presence bit;
- a flag saying whether the port's descriptor is compliant;
- four (min, max) voltage windows in millivolts;
- an LVDS flag.

It also receives a policy mode and one fallback voltage per group. A pass begins on `start`. The block captures every input on the accepting edge. It then sweeps candidate voltages upward in 100 mV steps from 1200 mV, testing one candidate per clock against all ports of all groups in parallel. Each group settles on the first candidate that fits every present member and its own bank window.

The policy mode decides how the per-group results turn into enables:
- Collective mode is all-or-nothing.
- Hybrid mode falls back to the configured voltage for an empty group.
- Fixed mode ignores the peripherals entirely.

A single non-compliant descriptor vetoes every group in the negotiating modes. When all groups are settled, the outputs are published and `done` pulses for one cycle. The outputs then hold until the next pass is published.

The interface carries no data stream. `start`/`done` is a plain control handshake with no back-pressure: a `start` that arrives while `busy` is high is dropped, not queued.

Top module: `vio_negotiator`

## Requirements
- R1: After reset, `busy`, `done`, `grp_en`, `grp_mv`, `grp_status` and `port_found` are all zero.
- R2: A negotiated group takes the lowest voltage of the form 1200 + 100·k mV that lies inside the group's bank window and inside at least one window of every present member. Bank windows are 1200–1800 mV for group 0 and 1200–3300 mV for group 1. A window whose min exceeds its max matches nothing. The group reports status 1 (solved).
- R3: A present member with its LVDS flag set allows only 1800 mV in group 0 and 2500 mV in group 1. If that value is not allowed, the group has no solution.
- R4: A group with present members but no common voltage reports status 2, has its enable low and drives 0 mV.
- R5: In modes 0, 1 and 3, a port that is present but not compliant makes every group report status 3, with all enables low and 0 mV.
- R6: In hybrid mode (mode 1), a group with no present member reports status 0 and enables its fallback voltage. A solved group is enabled independently of the other groups.
- R7: In collective mode (mode 0), if any group reports status 2, all enables are low. An empty group reports status 0 and stays disabled at 0 mV.
- R8: In fixed mode (mode 2), every group reports status 0 and is enabled at its fallback voltage. `port_found` is zero. Presence, compliance, windows and LVDS flags have no effect.
- R9: In modes 0, 1 and 3, `port_found[p]` is published as present AND compliant for port p.
- R10: `done` is high for exactly one cycle, while `busy` is low. `busy` is high from the accepting edge until the results are published. `done` rises on the second rising edge after the accepting edge when no sweep step is needed. Any pass completes within 25 cycles.
- R11: A `start` during `busy` is ignored. Accepting a start clears `grp_en` and `grp_mv`. Status and `port_found` change only together with `done`.
- R12: Mode 3 behaves exactly as collective mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| mode | input | 2 | 0 collective, 1 hybrid, 2 fixed, 3 collective |
| grp_default_mv | input | 24 | Fallback mV per group, group g at bits [12g+11:12g] |
| port_present | input | 3 | Peripheral detected, bit p = port p |
| port_desc_ok | input | 3 | Descriptor compliant, bit p = port p |
| port_lvds | input | 3 | Peripheral uses LVDS, bit p = port p |
| port_rng_min | input | 144 | Window minima, port p slot r at bits [(4p+r)*12 +: 12] |
| port_rng_max | input | 144 | Window maxima, same layout |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse when results are published |
| grp_mv | output | 24 | Applied mV per group, 0 when disabled |
| grp_en | output | 2 | Supply enable per group |
| grp_status | output | 4 | Per group: 0 default/empty, 1 solved, 2 no solution, 3 vetoed |
| port_found | output | 3 | Per-port identification result |

## Verification
The bound checker watches the following properties on every cycle:
- a disabled group always reads 0 mV;
- an enabled solved group stays inside its bank window;
- a veto status never coexists with an enable;
- collective mode never leaves a group enabled beside a failed group;
- fixed mode publishes all enables with no found ports;
- `done` is a lone pulse outside `busy`;
- status and identification change only together with `done`.

The voltage actually chosen can only be shown by the bench's scenarios. These cover the lowest grid point in overlapping windows, off-grid windows, LVDS pinning, hybrid fallback, mode 3 aliasing, the exact fixed-mode latency and a start dropped mid-pass.

// File: rtl/vio_pkg.sv
package vio_pkg;

  typedef enum logic [1:0] {
    MODE_COLLECT     = 2'd0,
    MODE_HYBRID      = 2'd1,
    MODE_FIXED       = 2'd2,
    MODE_COLLECT_ALT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    GST_DEFAULT = 2'd0,
    GST_SOLVED  = 2'd1,
    GST_NOSOL   = 2'd2,
    GST_VETO    = 2'd3
  } gstat_e;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_SWEEP   = 2'd1,
    S_PUBLISH = 2'd2
  } state_e;

  localparam int STW = 2;

endpackage

// File: rtl/vio_port_fit.sv
// Tests one candidate voltage against every window slot of one port.
module vio_port_fit #(
  parameter int NUM_RANGES = 4,
  parameter int VW         = 12
) (
  input  logic [VW-1:0]            cand,
  input  logic [NUM_RANGES*VW-1:0] rng_min,
  input  logic [NUM_RANGES*VW-1:0] rng_max,
  output logic                     fit
);

  logic [NUM_RANGES-1:0] hit;

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_slot
    logic [VW-1:0] lo;
    logic [VW-1:0] hi;
    assign lo = rng_min[r*VW +: VW];
    assign hi = rng_max[r*VW +: VW];
    // a slot with lo > hi is an empty slot and matches nothing
    assign hit[r] = (lo <= hi) && (cand >= lo) && (cand <= hi);
  end

  assign fit = |hit;

endmodule

// File: rtl/vio_group_eval.sv
// Combines per-port fits of one group with its bank window and LVDS rule.
module vio_group_eval #(
  parameter int                   NUM_PORTS = 3,
  parameter int                   VW        = 12,
  parameter logic [NUM_PORTS-1:0] MEMBERS   = '1,
  parameter logic [VW-1:0]        BANK_MIN  = 12'd1200,
  parameter logic [VW-1:0]        BANK_MAX  = 12'd1800,
  parameter logic [VW-1:0]        LVDS_MV   = 12'd1800
) (
  input  logic [VW-1:0]        cand,
  input  logic [NUM_PORTS-1:0] present,
  input  logic [NUM_PORTS-1:0] lvds,
  input  logic [NUM_PORTS-1:0] fit,
  output logic                 has_member,
  output logic                 fits,
  output logic                 exhausted
);

  logic                 lvds_hit;
  logic                 in_bank;
  logic [NUM_PORTS-1:0] port_ok;

  assign lvds_hit = (cand == LVDS_MV);
  assign in_bank  = (cand >= BANK_MIN) && (cand <= BANK_MAX);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_ok[p] = !MEMBERS[p] || !present[p] ||
                        (fit[p] && (!lvds[p] || lvds_hit));
  end

  assign has_member = |(present & MEMBERS);
  assign fits       = in_bank && (&port_ok);
  assign exhausted  = (cand > BANK_MAX);

endmodule

// File: rtl/vio_policy.sv
// Turns per-group statuses into enables according to the policy mode.
module vio_policy
  import vio_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int VW         = 12
) (
  input  mode_e                     mode,
  input  logic [NUM_GROUPS*STW-1:0] st,
  input  logic [NUM_GROUPS*VW-1:0]  raw_mv,
  output logic [NUM_GROUPS-1:0]     en,
  output logic [NUM_GROUPS*VW-1:0]  mv
);

  logic any_nosol;

  always_comb begin
    any_nosol = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (st[g*STW +: STW] == GST_NOSOL) any_nosol = 1'b1;
    end
  end

  always_comb begin
    en = '0;
    mv = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      case (mode)
        MODE_HYBRID: en[g] = (st[g*STW +: STW] == GST_DEFAULT) ||
                             (st[g*STW +: STW] == GST_SOLVED);
        MODE_FIXED:  en[g] = 1'b1;
        default:     en[g] = (st[g*STW +: STW] == GST_SOLVED) && !any_nosol;
      endcase
      mv[g*VW +: VW] = en[g] ? raw_mv[g*VW +: VW] : '0;
    end
  end

endmodule

// File: rtl/vio_negotiator.sv
module vio_negotiator
  import vio_pkg::*;
#(
  parameter int NUM_PORTS   = 3,
  parameter int NUM_GROUPS  = 2,
  parameter int NUM_RANGES  = 4,
  parameter int VW          = 12,
  parameter int STEP_MV     = 100,
  parameter int SWEEP_LO_MV = 1200,
  parameter int SWEEP_HI_MV = 3300,
  parameter logic [NUM_GROUPS*NUM_PORTS-1:0] GRP_PORTS   = {3'b100, 3'b011},
  parameter logic [NUM_GROUPS*VW-1:0]        BANK_MIN_MV = {12'd1200, 12'd1200},
  parameter logic [NUM_GROUPS*VW-1:0]        BANK_MAX_MV = {12'd3300, 12'd1800},
  parameter logic [NUM_GROUPS*VW-1:0]        LVDS_MV     = {12'd2500, 12'd1800}
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [1:0]                        mode,
  input  logic [NUM_GROUPS*VW-1:0]          grp_default_mv,
  input  logic [NUM_PORTS-1:0]              port_present,
  input  logic [NUM_PORTS-1:0]              port_desc_ok,
  input  logic [NUM_PORTS-1:0]              port_lvds,
  input  logic [NUM_PORTS*NUM_RANGES*VW-1:0] port_rng_min,
  input  logic [NUM_PORTS*NUM_RANGES*VW-1:0] port_rng_max,
  output logic                              busy,
  output logic                              done,
  output logic [NUM_GROUPS*VW-1:0]          grp_mv,
  output logic [NUM_GROUPS-1:0]             grp_en,
  output logic [NUM_GROUPS*STW-1:0]         grp_status,
  output logic [NUM_PORTS-1:0]              port_found
);

  localparam int            RW        = NUM_RANGES * VW;
  localparam logic [VW-1:0] CAND_LO   = VW'(SWEEP_LO_MV);
  localparam logic [VW-1:0] CAND_HI   = VW'(SWEEP_HI_MV);
  localparam logic [VW-1:0] CAND_STEP = VW'(STEP_MV);

  state_e                    state_q;
  mode_e                     s_mode;
  logic [NUM_PORTS-1:0]      s_present;
  logic [NUM_PORTS-1:0]      s_ok;
  logic [NUM_PORTS-1:0]      s_lvds;
  logic [NUM_PORTS*RW-1:0]   s_min;
  logic [NUM_PORTS*RW-1:0]   s_max;
  logic [NUM_GROUPS*VW-1:0]  s_def;
  logic [VW-1:0]             cand_q;

  logic [NUM_GROUPS-1:0]     resolved_q;
  logic [NUM_GROUPS-1:0]     resolved_d;
  logic [NUM_GROUPS*VW-1:0]  res_mv_q;
  logic [NUM_GROUPS*VW-1:0]  res_mv_d;
  logic [NUM_GROUPS*STW-1:0] res_st_q;
  logic [NUM_GROUPS*STW-1:0] res_st_d;

  logic [NUM_PORTS-1:0]      port_fit;
  logic [NUM_GROUPS-1:0]     pol_en;
  logic [NUM_GROUPS*VW-1:0]  pol_mv;
  logic                      is_fixed;
  logic                      is_hybrid;
  logic                      veto;
  logic                      past_top;

  assign is_fixed  = (s_mode == MODE_FIXED);
  assign is_hybrid = (s_mode == MODE_HYBRID);
  assign veto      = !is_fixed && (|(s_present & ~s_ok));
  assign past_top  = (cand_q > CAND_HI);
  assign busy      = (state_q != S_IDLE);

  // per-port window match, all ports evaluated on the same candidate
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fit
    vio_port_fit #(
      .NUM_RANGES (NUM_RANGES),
      .VW         (VW)
    ) u_fit (
      .cand    (cand_q),
      .rng_min (s_min[p*RW +: RW]),
      .rng_max (s_max[p*RW +: RW]),
      .fit     (port_fit[p])
    );
  end

  // per-group evaluation and resolution
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic          has_member;
    logic          fits;
    logic          exhausted;
    logic          nx_res;
    logic [VW-1:0] nx_mv;
    logic [STW-1:0] nx_st;

    vio_group_eval #(
      .NUM_PORTS (NUM_PORTS),
      .VW        (VW),
      .MEMBERS   (GRP_PORTS[g*NUM_PORTS +: NUM_PORTS]),
      .BANK_MIN  (BANK_MIN_MV[g*VW +: VW]),
      .BANK_MAX  (BANK_MAX_MV[g*VW +: VW]),
      .LVDS_MV   (LVDS_MV[g*VW +: VW])
    ) u_eval (
      .cand       (cand_q),
      .present    (s_present),
      .lvds       (s_lvds),
      .fit        (port_fit),
      .has_member (has_member),
      .fits       (fits),
      .exhausted  (exhausted)
    );

    always_comb begin
      nx_res = resolved_q[g];
      nx_mv  = res_mv_q[g*VW +: VW];
      nx_st  = res_st_q[g*STW +: STW];
      if (!resolved_q[g]) begin
        if (is_fixed) begin
          nx_res = 1'b1;
          nx_mv  = s_def[g*VW +: VW];
          nx_st  = GST_DEFAULT;
        end else if (veto) begin
          nx_res = 1'b1;
          nx_mv  = '0;
          nx_st  = GST_VETO;
        end else if (!has_member) begin
          nx_res = 1'b1;
          nx_mv  = is_hybrid ? s_def[g*VW +: VW] : '0;
          nx_st  = GST_DEFAULT;
        end else if (fits) begin
          nx_res = 1'b1;
          nx_mv  = cand_q;
          nx_st  = GST_SOLVED;
        end else if (exhausted || past_top) begin
          nx_res = 1'b1;
          nx_mv  = '0;
          nx_st  = GST_NOSOL;
        end
      end
    end

    assign resolved_d[g]            = nx_res;
    assign res_mv_d[g*VW +: VW]     = nx_mv;
    assign res_st_d[g*STW +: STW]   = nx_st;
  end

  vio_policy #(
    .NUM_GROUPS (NUM_GROUPS),
    .VW         (VW)
  ) u_policy (
    .mode   (s_mode),
    .st     (res_st_q),
    .raw_mv (res_mv_q),
    .en     (pol_en),
    .mv     (pol_mv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      s_mode     <= MODE_COLLECT;
      s_present  <= '0;
      s_ok       <= '0;
      s_lvds     <= '0;
      s_min      <= '0;
      s_max      <= '0;
      s_def      <= '0;
      cand_q     <= '0;
      resolved_q <= '0;
      res_mv_q   <= '0;
      res_st_q   <= '0;
      done       <= 1'b0;
      grp_mv     <= '0;
      grp_en     <= '0;
      grp_status <= '0;
      port_found <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            s_mode     <= mode_e'(mode);
            s_present  <= port_present;
            s_ok       <= port_desc_ok;
            s_lvds     <= port_lvds;
            s_min      <= port_rng_min;
            s_max      <= port_rng_max;
            s_def      <= grp_default_mv;
            cand_q     <= CAND_LO;
            resolved_q <= '0;
            grp_en     <= '0;
            grp_mv     <= '0;
            state_q    <= S_SWEEP;
          end
        end
        S_SWEEP: begin
          resolved_q <= resolved_d;
          res_mv_q   <= res_mv_d;
          res_st_q   <= res_st_d;
          cand_q     <= cand_q + CAND_STEP;
          if (&resolved_d) state_q <= S_PUBLISH;
        end
        S_PUBLISH: begin
          grp_mv     <= pol_mv;
          grp_en     <= pol_en;
          grp_status <= res_st_q;
          port_found <= is_fixed ? '0 : (s_present & s_ok);
          done       <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vio_negotiator_chk.sv
module vio_negotiator_chk #(
  parameter int NUM_PORTS  = 3,
  parameter int NUM_GROUPS = 2,
  parameter int VW         = 12,
  parameter logic [NUM_GROUPS*VW-1:0] BANK_MIN_MV = {12'd1200, 12'd1200},
  parameter logic [NUM_GROUPS*VW-1:0] BANK_MAX_MV = {12'd3300, 12'd1800}
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    done,
  input logic [NUM_GROUPS*VW-1:0] grp_mv,
  input logic [NUM_GROUPS-1:0]   grp_en,
  input logic [NUM_GROUPS*2-1:0] grp_status,
  input logic [NUM_PORTS-1:0]    port_found,
  input logic [1:0]              snap_mode
);

  logic any_nosol;
  logic collect_mode;

  always_comb begin
    any_nosol = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_status[g*2 +: 2] == 2'd2) any_nosol = 1'b1;
    end
  end

  assign collect_mode = (snap_mode == 2'd0) || (snap_mode == 2'd3);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  publish_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(grp_status) && $stable(port_found)));

  // R7
  collect_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && collect_mode && any_nosol) |-> (grp_en == '0));

  // R8
  fixed_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && snap_mode == 2'd2) |-> ((&grp_en) && port_found == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    // R4
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_en[g] |-> (grp_mv[g*VW +: VW] == '0));

    // R2
    in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_en[g] && grp_status[g*2 +: 2] == 2'd1) |->
        (grp_mv[g*VW +: VW] >= BANK_MIN_MV[g*VW +: VW] &&
         grp_mv[g*VW +: VW] <= BANK_MAX_MV[g*VW +: VW]));

    // R5
    veto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && grp_status[g*2 +: 2] == 2'd3) |-> (grp_en == '0));
  end

endmodule

bind vio_negotiator vio_negotiator_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .NUM_GROUPS  (NUM_GROUPS),
  .VW          (VW),
  .BANK_MIN_MV (BANK_MIN_MV),
  .BANK_MAX_MV (BANK_MAX_MV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .grp_mv     (grp_mv),
  .grp_en     (grp_en),
  .grp_status (grp_status),
  .port_found (port_found),
  .snap_mode  (s_mode)
);

// File: tb/sim_vio_negotiator.sv
`timescale 1ns/1ps
module sim_vio_negotiator;

  localparam int NP = 3;
  localparam int NG = 2;
  localparam int NR = 4;
  localparam int VW = 12;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  pres;
    logic [2:0]  ok;
    logic [2:0]  lvds;
    logic [11:0] mn0, mx0, mn1, mx1, mn2, mx2;
    logic [11:0] e_mv0, e_mv1;
    logic [1:0]  e_en;
    logic [1:0]  e_st0, e_st1;
    logic [2:0]  e_found;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // 0 R2: overlapping windows, hybrid
    '{2'd1, 3'b111, 3'b111, 3'b000, 12'd1250, 12'd3300, 12'd1000, 12'd1600, 12'd2000, 12'd3000,
      12'd1300, 12'd2000, 2'b11, 2'd1, 2'd1, 3'b111},
    // 1 R6: empty group 0 falls back
    '{2'd1, 3'b100, 3'b111, 3'b000, 12'd1200, 12'd1300, 12'd1200, 12'd1300, 12'd1500, 12'd2600,
      12'd1500, 12'd1500, 2'b11, 2'd0, 2'd1, 3'b100},
    // 2 R4: group 0 above bank window, hybrid
    '{2'd1, 3'b011, 3'b011, 3'b000, 12'd2500, 12'd3300, 12'd1200, 12'd3300, 12'd1200, 12'd3300,
      12'd0, 12'd2500, 2'b10, 2'd2, 2'd0, 3'b011},
    // 3 R7: same inputs, collective
    '{2'd0, 3'b011, 3'b011, 3'b000, 12'd2500, 12'd3300, 12'd1200, 12'd3300, 12'd1200, 12'd3300,
      12'd0, 12'd0, 2'b00, 2'd2, 2'd0, 3'b011},
    // 4 R2: collective success, top of sweep
    '{2'd0, 3'b111, 3'b111, 3'b000, 12'd1200, 12'd1800, 12'd1400, 12'd1900, 12'd3300, 12'd3300,
      12'd1400, 12'd3300, 2'b11, 2'd1, 2'd1, 3'b111},
    // 5 R5: non-compliant port vetoes all
    '{2'd1, 3'b111, 3'b101, 3'b000, 12'd1200, 12'd3300, 12'd1200, 12'd3300, 12'd1200, 12'd3300,
      12'd0, 12'd0, 2'b00, 2'd3, 2'd3, 3'b101},
    // 6 R8: fixed mode ignores everything
    '{2'd2, 3'b111, 3'b000, 3'b111, 12'd1200, 12'd1300, 12'd1200, 12'd1300, 12'd1200, 12'd1300,
      12'd1500, 12'd2500, 2'b11, 2'd0, 2'd0, 3'b000},
    // 7 R3: LVDS pins both groups
    '{2'd1, 3'b111, 3'b111, 3'b101, 12'd1200, 12'd3300, 12'd1200, 12'd3300, 12'd1200, 12'd3300,
      12'd1800, 12'd2500, 2'b11, 2'd1, 2'd1, 3'b111},
    // 8 R3: LVDS value outside window
    '{2'd1, 3'b111, 3'b111, 3'b001, 12'd1200, 12'd1700, 12'd1200, 12'd3300, 12'd1900, 12'd2000,
      12'd0, 12'd1900, 2'b10, 2'd2, 2'd1, 3'b111},
    // 9 R12: mode 3 equals collective
    '{2'd3, 3'b011, 3'b011, 3'b000, 12'd2500, 12'd3300, 12'd1200, 12'd3300, 12'd1200, 12'd3300,
      12'd0, 12'd0, 2'b00, 2'd2, 2'd0, 3'b011},
    // 10 R7: collective, nothing present
    '{2'd0, 3'b000, 3'b000, 3'b000, 12'd1200, 12'd3300, 12'd1200, 12'd3300, 12'd1200, 12'd3300,
      12'd0, 12'd0, 2'b00, 2'd0, 2'd0, 3'b000},
    // 11 R4: off-grid window has no candidate
    '{2'd1, 3'b101, 3'b101, 3'b000, 12'd1210, 12'd1290, 12'd1200, 12'd3300, 12'd1250, 12'd1350,
      12'd0, 12'd1300, 2'b10, 2'd2, 2'd1, 3'b101}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        mode = '0;
  logic [NG*VW-1:0]  defs = {12'd2500, 12'd1500};
  logic [NP-1:0]     present = '0;
  logic [NP-1:0]     ok = '0;
  logic [NP-1:0]     lvds = '0;
  logic [NP*NR*VW-1:0] rmin = '1;
  logic [NP*NR*VW-1:0] rmax = '0;
  logic              busy, done;
  logic [NG*VW-1:0]  grp_mv;
  logic [NG-1:0]     grp_en;
  logic [NG*2-1:0]   grp_status;
  logic [NP-1:0]     port_found;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vio_negotiator u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .mode           (mode),
    .grp_default_mv (defs),
    .port_present   (present),
    .port_desc_ok   (ok),
    .port_lvds      (lvds),
    .port_rng_min   (rmin),
    .port_rng_max   (rmax),
    .busy           (busy),
    .done           (done),
    .grp_mv         (grp_mv),
    .grp_en         (grp_en),
    .grp_status     (grp_status),
    .port_found     (port_found)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_range(input int p, input int r, input logic [11:0] mn, input logic [11:0] mx);
    rmin[(p*NR+r)*VW +: VW] = mn;
    rmax[(p*NR+r)*VW +: VW] = mx;
  endtask

  task automatic apply_vec(input vec_t v);
    mode    = v.mode;
    present = v.pres;
    ok      = v.ok;
    lvds    = v.lvds;
    rmin    = '1;
    rmax    = '0;
    set_range(0, 0, v.mn0, v.mx0);
    set_range(1, 0, v.mn1, v.mx1);
    set_range(2, 0, v.mn2, v.mx2);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 1;
    while (!done && cycles < 40) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic check_result(input string req, input vec_t v, input string freq);
    chk(req, "grp_mv[0]", int'(grp_mv[11:0]), int'(v.e_mv0));
    chk(req, "grp_mv[1]", int'(grp_mv[23:12]), int'(v.e_mv1));
    chk(req, "grp_en", int'(grp_en), int'(v.e_en));
    chk(req, "status[0]", int'(grp_status[1:0]), int'(v.e_st0));
    chk(req, "status[1]", int'(grp_status[3:2]), int'(v.e_st1));
    chk(freq, "port_found", int'(port_found), int'(v.e_found));
  endtask

  function automatic string vreq(input int i);
    case (i)
      0, 4:    return "R2";
      1:       return "R6";
      2, 11:   return "R4";
      3, 10:   return "R7";
      5:       return "R5";
      6:       return "R8";
      7, 8:    return "R3";
      default: return "R12";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "grp_en", int'(grp_en), 0);
    chk("R1", "grp_mv", int'(grp_mv), 0);
    chk("R1", "status", int'(grp_status), 0);
    chk("R1", "port_found", int'(port_found), 0);

    for (int i = 0; i < NV; i++) begin
      apply_vec(VECS[i]);
      pulse_start();
      wait_done(cyc);
      chk("R10", "completion bound", int'(cyc <= 25), 1);
      check_result(vreq(i), VECS[i], (i == 6) ? "R8" : "R9");
      @(negedge clk);
    end

    // R2: several window slots per port, lowest hit in slot 3; slot 1 has min > max
    apply_vec(VECS[0]);
    mode = 2'd1; present = 3'b001; ok = 3'b001; lvds = 3'b000;
    rmin = '1; rmax = '0;
    set_range(0, 0, 12'd1600, 12'd1800);
    set_range(0, 1, 12'd1300, 12'd1250);
    set_range(0, 3, 12'd1200, 12'd1300);
    pulse_start();
    wait_done(cyc);
    chk("R2", "multi-slot mv[0]", int'(grp_mv[11:0]), 1200);
    chk("R6", "fallback mv[1]", int'(grp_mv[23:12]), 2500);
    @(negedge clk);

    // R10: fixed mode latency and busy
    apply_vec(VECS[6]);
    pulse_start();
    chk("R10", "busy after accept", int'(busy), 1);
    wait_done(cyc);
    chk("R10", "fixed-mode latency", cyc, 3);
    @(negedge clk);
    chk("R10", "done single cycle", int'(done), 0);

    // R11: start during busy ignored, enables cleared at accept
    apply_vec(VECS[0]);
    pulse_start();
    wait_done(cyc);
    chk("R11", "prior enables", int'(grp_en), 3);
    @(negedge clk);
    apply_vec(VECS[4]);
    pulse_start();
    chk("R11", "enables cleared at accept", int'(grp_en), 0);
    chk("R11", "mv cleared at accept", int'(grp_mv), 0);
    repeat (2) @(negedge clk);
    apply_vec(VECS[6]);
    pulse_start();
    wait_done(cyc);
    check_result("R11", VECS[4], "R11");
    begin
      int extra = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R11", "no second pass", extra, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule